// File: doc/BRIEF.md
# Block-Mode Transfer Address Sequencer

This block is the address and counter engine of a descriptor-driven transfer controller working in block mode. A single activation request, accepted while the engine is idle, moves one complete block of units from a source region to a destination region. Each unit is a byte, a 16-bit word or a 32-bit longword. Each unit is carried as one read, followed by one write over a simple single-beat memory port with a ready handshake.

A select bit marks one side, either the source or the destination, as the repeating block area. Within a block, that side's address advances by the unit size on every unit. At block end, it snaps back to its value from the start of the block, and the unit counter is reloaded from the stored block size. The other side's address moves once per unit: up, down, or not at all.

After the last unit, the engine presents the updated descriptor fields on a writeback port for one cycle. It then pulses done. When the block counter runs out, it also raises a sticky interrupt request that stays high until acknowledged.

Top module: `blk_xfer_seq`

## Requirements
- R1: An activation accepted while idle makes exactly N units, where N is the block size field, and a field value of 0 means 256. Each unit is one read from the source address, then one write to the destination address that carries the data returned by that read. The next unit's read starts only after the write is accepted.
- R2: While memReq is high and memRdy is low, memReq stays high and memAddr, memWe and memSize hold their values.
- R3: memSize carries the unit code: 0 = byte, 1 = word, 2 = longword (3 acts as longword). The per-unit address step is 1, 2 or 4 bytes to match.
- R4: With cfgBlkIsSrc = 1 the source address is the block area; with 0 the destination address is. The block-area address rises by one step per unit within the block.
- R5: The non-block address follows cfgOtherMode: 0 = held, 1 = incremented by one step per unit, 2 = decremented by one step per unit, 3 = held.
- R6: In the cycle after the last write is accepted, wbValid is high for one cycle. At that point, wbSrcAddr and wbDstAddr show the block-side start address and the stepped non-block address. wbUnitCnt shows the stored block size, and wbBlkCnt shows the old block count minus 1, modulo 2^16.
- R7: doneP is high for exactly one cycle, the cycle right after wbValid.
- R8: irq rises together with doneP when the block count at activation was 1. A count of 0 stands for 65,536 and writes back 0xFFFF without raising irq.
- R9: irq stays high until a cycle with irqAck high. A new interrupt in the same cycle as irqAck wins.
- R10: actReq is ignored while a block is in progress: no extra accesses and no extra writeback result.
- R11: During reset, memReq, wbValid, doneP and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actReq | input | 1 | Activation request, sampled when idle |
| cfgSrcAddr | input | 32 | Descriptor source address |
| cfgDstAddr | input | 32 | Descriptor destination address |
| cfgBlkSize | input | 8 | Block size in units (0 = 256) |
| cfgBlkCnt | input | 16 | Remaining block count (0 = 65,536) |
| cfgUnit | input | 2 | Unit size code |
| cfgBlkIsSrc | input | 1 | 1: source is block area, 0: destination is |
| cfgOtherMode | input | 2 | Step mode of the non-block address |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Access address |
| memSize | output | 2 | Unit size code of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memRdy on a read |
| memRdy | input | 1 | Access accepted this cycle |
| wbValid | output | 1 | Writeback fields valid |
| wbSrcAddr | output | 32 | Updated source address |
| wbDstAddr | output | 32 | Updated destination address |
| wbUnitCnt | output | 8 | Reloaded unit counter |
| wbBlkCnt | output | 16 | Decremented block counter |
| doneP | output | 1 | One-cycle end-of-activation pulse |
| irq | output | 1 | Sticky interrupt request |
| irqAck | input | 1 | Clears irq |

## Verification
The handshake assertions assume that memRdy is only meaningful while memReq is high. The bench drives memRdy from a random choice that is gated by memReq, with stalls of varying length. The interrupt assertions assume that irqAck is a level that the environment may hold at any time. The bench holds it across an interrupt-raising writeback so that the set-over-clear case is covered. The bench raises actReq only when idle for new work, except for one deliberate pulse in the middle of a long block.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    UNIT_BYTE = 2'd0,
    UNIT_WORD = 2'd1,
    UNIT_LONG = 2'd2,
    UNIT_RSVD = 2'd3
  } unitSel_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_HOLDX = 2'd3
  } stepMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_WBACK = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture descriptor
    logic readDone;   // read accepted, latch data
    logic unitDone;   // write accepted, advance addresses
    logic blockEnd;   // the accepted write was the last unit
    logic wbFire;     // writeback cycle
  } seqStrobe_t;

endpackage

// File: rtl/bxs_ctrl.sv
module bxs_ctrl
  import blk_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actReq,
  input  logic       memRdy,
  input  logic       lastUnit,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       wbValid,
  output logic       doneP
);

  seqState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    wbValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (actReq) begin
          strobe.load = 1'b1;
          stateNxt    = ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memRdy) begin
          strobe.readDone = 1'b1;
          stateNxt        = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memRdy) begin
          strobe.unitDone = 1'b1;
          if (lastUnit) begin
            strobe.blockEnd = 1'b1;
            stateNxt        = ST_WBACK;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      ST_WBACK: begin
        wbValid       = 1'b1;
        strobe.wbFire = 1'b1;
        stateNxt      = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneP <= 1'b0;
    end else begin
      state <= stateNxt;
      doneP <= (state == ST_WBACK);
    end
  end

endmodule

// File: rtl/bxs_datapath.sv
module bxs_datapath
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              wrPhase,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [SIZE_W-1:0] cfgBlkSize,
  input  logic [CNT_W-1:0]  cfgBlkCnt,
  input  logic [1:0]        cfgUnit,
  input  logic              cfgBlkIsSrc,
  input  logic [1:0]        cfgOtherMode,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              irqAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic              lastUnit,
  output logic [ADDR_W-1:0] wbSrcAddr,
  output logic [ADDR_W-1:0] wbDstAddr,
  output logic [SIZE_W-1:0] wbUnitCnt,
  output logic [CNT_W-1:0]  wbBlkCnt,
  output logic              irq
);

  localparam logic [SIZE_W-1:0] UNIT_ONE = SIZE_W'(1);
  localparam logic [CNT_W-1:0]  BLK_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] srcAddr, dstAddr, baseAddr;
  logic [SIZE_W-1:0] sizeStore, unitCnt;
  logic [CNT_W-1:0]  blkCnt;
  unitSel_e          unitSel;
  stepMode_e         otherMode;
  logic              blkIsSrc;
  logic              lastBlk;
  logic [DATA_W-1:0] dataReg;

  logic [ADDR_W-1:0] stepAmt, blkSide, otherSide, blkNext, otherNext;

  always_comb begin
    unique case (unitSel)
      UNIT_BYTE: stepAmt = ADDR_W'(1);
      UNIT_WORD: stepAmt = ADDR_W'(2);
      default:   stepAmt = ADDR_W'(4);
    endcase
  end

  assign blkSide   = blkIsSrc ? srcAddr : dstAddr;
  assign otherSide = blkIsSrc ? dstAddr : srcAddr;
  assign blkNext   = blkSide + stepAmt;

  always_comb begin
    unique case (otherMode)
      STEP_UP:   otherNext = otherSide + stepAmt;
      STEP_DOWN: otherNext = otherSide - stepAmt;
      default:   otherNext = otherSide;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      baseAddr  <= '0;
      sizeStore <= '0;
      unitCnt   <= '0;
      blkCnt    <= '0;
      unitSel   <= UNIT_BYTE;
      otherMode <= STEP_HOLD;
      blkIsSrc  <= 1'b0;
      lastBlk   <= 1'b0;
      dataReg   <= '0;
      irq       <= 1'b0;
    end else begin
      if (strobe.load) begin
        srcAddr   <= cfgSrcAddr;
        dstAddr   <= cfgDstAddr;
        baseAddr  <= cfgBlkIsSrc ? cfgSrcAddr : cfgDstAddr;
        sizeStore <= cfgBlkSize;
        unitCnt   <= cfgBlkSize;
        blkCnt    <= cfgBlkCnt;
        unitSel   <= unitSel_e'(cfgUnit);
        otherMode <= stepMode_e'(cfgOtherMode);
        blkIsSrc  <= cfgBlkIsSrc;
        lastBlk   <= 1'b0;
      end
      if (strobe.readDone) dataReg <= memRdata;
      if (strobe.unitDone) begin
        if (blkIsSrc) begin
          srcAddr <= strobe.blockEnd ? baseAddr : blkNext;
          dstAddr <= otherNext;
        end else begin
          dstAddr <= strobe.blockEnd ? baseAddr : blkNext;
          srcAddr <= otherNext;
        end
        if (strobe.blockEnd) begin
          unitCnt <= sizeStore;
          blkCnt  <= blkCnt - BLK_ONE;
          lastBlk <= (blkCnt == BLK_ONE);
        end else begin
          unitCnt <= unitCnt - UNIT_ONE;
        end
      end
      if (strobe.wbFire && lastBlk) irq <= 1'b1;
      else if (irqAck)              irq <= 1'b0;
    end
  end

  assign lastUnit  = (unitCnt == UNIT_ONE);
  assign memAddr   = wrPhase ? dstAddr : srcAddr;
  assign memSize   = unitSel;
  assign memWdata  = dataReg;
  assign wbSrcAddr = srcAddr;
  assign wbDstAddr = dstAddr;
  assign wbUnitCnt = unitCnt;
  assign wbBlkCnt  = blkCnt;

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actReq,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [SIZE_W-1:0] cfgBlkSize,
  input  logic [CNT_W-1:0]  cfgBlkCnt,
  input  logic [1:0]        cfgUnit,
  input  logic              cfgBlkIsSrc,
  input  logic [1:0]        cfgOtherMode,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memRdy,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbSrcAddr,
  output logic [ADDR_W-1:0] wbDstAddr,
  output logic [SIZE_W-1:0] wbUnitCnt,
  output logic [CNT_W-1:0]  wbBlkCnt,
  output logic              doneP,
  output logic              irq,
  input  logic              irqAck
);

  seqStrobe_t strobe;
  logic       lastUnit;

  bxs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .actReq   (actReq),
    .memRdy   (memRdy),
    .lastUnit (lastUnit),
    .strobe   (strobe),
    .memReq   (memReq),
    .memWe    (memWe),
    .wbValid  (wbValid),
    .doneP    (doneP)
  );

  bxs_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SIZE_W (SIZE_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrPhase      (memWe),
    .cfgSrcAddr   (cfgSrcAddr),
    .cfgDstAddr   (cfgDstAddr),
    .cfgBlkSize   (cfgBlkSize),
    .cfgBlkCnt    (cfgBlkCnt),
    .cfgUnit      (cfgUnit),
    .cfgBlkIsSrc  (cfgBlkIsSrc),
    .cfgOtherMode (cfgOtherMode),
    .memRdata     (memRdata),
    .irqAck       (irqAck),
    .memAddr      (memAddr),
    .memSize      (memSize),
    .memWdata     (memWdata),
    .lastUnit     (lastUnit),
    .wbSrcAddr    (wbSrcAddr),
    .wbDstAddr    (wbDstAddr),
    .wbUnitCnt    (wbUnitCnt),
    .wbBlkCnt     (wbBlkCnt),
    .irq          (irq)
  );

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memSize,
  input logic              memRdy,
  input logic              wbValid,
  input logic              doneP,
  input logic              irq,
  input logic              irqAck
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRdy |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memSize)); // R2

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memRdy |=> memReq && memWe); // R1

  AST_NO_ACCESS_IN_WB: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !memReq); // R6

  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid); // R6

  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> doneP); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP); // R7

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> doneP); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqAck |=> irq); // R9

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAddr (memAddr),
  .memSize (memSize),
  .memRdy  (memRdy),
  .wbValid (wbValid),
  .doneP   (doneP),
  .irq     (irq),
  .irqAck  (irqAck)
);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        actReq = 1'b0;
  logic [31:0] cfgSrcAddr = '0, cfgDstAddr = '0;
  logic [7:0]  cfgBlkSize = '0;
  logic [15:0] cfgBlkCnt = '0;
  logic [1:0]  cfgUnit = '0, cfgOtherMode = '0;
  logic        cfgBlkIsSrc = 1'b0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0]  memSize;
  logic        memRdy = 1'b0;
  logic        wbValid, doneP, irq;
  logic [31:0] wbSrcAddr, wbDstAddr;
  logic [7:0]  wbUnitCnt;
  logic [15:0] wbBlkCnt;
  logic        irqAck = 1'b0;

  int errors = 0;
  int checks = 0;
  int doneSeen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rstN(rstN), .actReq(actReq),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr), .cfgBlkSize(cfgBlkSize),
    .cfgBlkCnt(cfgBlkCnt), .cfgUnit(cfgUnit), .cfgBlkIsSrc(cfgBlkIsSrc),
    .cfgOtherMode(cfgOtherMode), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata), .memRdy(memRdy),
    .wbValid(wbValid), .wbSrcAddr(wbSrcAddr), .wbDstAddr(wbDstAddr),
    .wbUnitCnt(wbUnitCnt), .wbBlkCnt(wbBlkCnt), .doneP(doneP), .irq(irq),
    .irqAck(irqAck)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  assign memRdata = pat(memAddr);

  // memory responder with random stalls
  always @(posedge clk) begin
    #1;
    memRdy = memReq && ($urandom_range(0, 2) != 0);
  end

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
  } xact_t;

  typedef struct {
    logic [31:0] src;
    logic [31:0] dst;
    logic [7:0]  unitCnt;
    logic [15:0] blkCnt;
    bit          last;
  } wb_t;

  xact_t expX[$];
  wb_t   expW[$];
  bit    doneExp = 0;
  bit    irqExp  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit lastNow;
      lastNow = 0;
      check(doneP == doneExp, "R7", "doneP", 32'(doneP), 32'(doneExp));
      check(irq == irqExp, "R9", "irq level", 32'(irq), 32'(irqExp));
      if (memReq && memRdy) begin
        if (expX.size() == 0) begin
          check(0, "R10", "unexpected access", memAddr, 32'hFFFF_FFFF);
        end else begin
          xact_t e;
          e = expX.pop_front();
          check(memWe == e.we, "R1", "access direction", 32'(memWe), 32'(e.we));
          check(memAddr == e.addr, e.we ? "R4" : "R5", "access address", memAddr, e.addr);
          check(memSize == e.size, "R3", "unit code", 32'(memSize), 32'(e.size));
          if (e.we) check(memWdata == e.data, "R1", "write data", memWdata, e.data);
        end
      end
      if (wbValid) begin
        if (expW.size() == 0) begin
          check(0, "R10", "unexpected writeback", wbSrcAddr, 32'hFFFF_FFFF);
        end else begin
          wb_t w;
          w = expW.pop_front();
          check(expX.size() == 0, "R1", "units left at writeback", 32'(expX.size()), 0);
          check(wbSrcAddr == w.src, "R6", "wb source", wbSrcAddr, w.src);
          check(wbDstAddr == w.dst, "R6", "wb destination", wbDstAddr, w.dst);
          check(wbUnitCnt == w.unitCnt, "R6", "wb unit count", 32'(wbUnitCnt), 32'(w.unitCnt));
          check(wbBlkCnt == w.blkCnt, "R8", "wb block count", 32'(wbBlkCnt), 32'(w.blkCnt));
          lastNow = w.last;
        end
      end
      if (doneP) doneSeen++;
      doneExp = wbValid;
      if (wbValid && lastNow) irqExp = 1;
      else if (irqAck)        irqExp = 0;
    end
  end

  task automatic expectBlock(input logic [31:0] src, input logic [31:0] dst,
                             input logic [7:0] size, input logic [15:0] cnt,
                             input logic [1:0] unit, input bit isSrc,
                             input logic [1:0] mode);
    logic [31:0] ub, base, other, b, o, sA, dA;
    int n;
    ub    = (unit == 2'd0) ? 32'd1 : (unit == 2'd1) ? 32'd2 : 32'd4;
    base  = isSrc ? src : dst;
    other = isSrc ? dst : src;
    n     = (size == 8'd0) ? 256 : int'(size);
    for (int i = 0; i < n; i++) begin
      b = base + 32'(i) * ub;
      o = (mode == 2'd1) ? other + 32'(i) * ub :
          (mode == 2'd2) ? other - 32'(i) * ub : other;
      sA = isSrc ? b : o;
      dA = isSrc ? o : b;
      expX.push_back('{we: 1'b0, addr: sA, size: unit, data: 32'h0});
      expX.push_back('{we: 1'b1, addr: dA, size: unit, data: pat(sA)});
    end
    o = (mode == 2'd1) ? other + 32'(n) * ub :
        (mode == 2'd2) ? other - 32'(n) * ub : other;
    expW.push_back('{src: isSrc ? base : o, dst: isSrc ? o : base,
                     unitCnt: size, blkCnt: cnt - 16'd1, last: (cnt == 16'd1)});
  endtask

  // called just after a rising edge
  task automatic runBlock(input logic [31:0] src, input logic [31:0] dst,
                          input logic [7:0] size, input logic [15:0] cnt,
                          input logic [1:0] unit, input bit isSrc,
                          input logic [1:0] mode, input bit poke);
    int startDone;
    startDone = doneSeen;
    expectBlock(src, dst, size, cnt, unit, isSrc, mode);
    cfgSrcAddr = src; cfgDstAddr = dst; cfgBlkSize = size; cfgBlkCnt = cnt;
    cfgUnit = unit; cfgBlkIsSrc = isSrc; cfgOtherMode = mode;
    actReq = 1'b1;
    @(posedge clk); #1;
    actReq = 1'b0;
    if (poke) begin
      // R10: activation with a different descriptor mid-block
      repeat (3) @(posedge clk);
      #1;
      cfgSrcAddr = 32'hDEAD_0000; cfgDstAddr = 32'hBEEF_0000; cfgBlkSize = 8'd9;
      cfgBlkCnt = 16'd1; cfgBlkIsSrc = ~isSrc;
      actReq = 1'b1;
      @(posedge clk); #1;
      actReq = 1'b0;
    end
    while (doneSeen == startDone) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check(memReq == 0, "R11", "memReq in reset", 32'(memReq), 0);
    check(wbValid == 0, "R11", "wbValid in reset", 32'(wbValid), 0);
    check(doneP == 0, "R11", "doneP in reset", 32'(doneP), 0);
    check(irq == 0, "R11", "irq in reset", 32'(irq), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #1;

    // R4 R5: source block area, words, destination incrementing, mid-block poke R10
    runBlock(32'h0000_1000, 32'h0000_8000, 8'd6, 16'd3, 2'd1, 1'b1, 2'd1, 1'b1);
    // R4 R5: destination block area, longwords, source decrementing, last block R8
    runBlock(32'h0000_4000, 32'h0002_0000, 8'd3, 16'd1, 2'd2, 1'b0, 2'd2, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    irqAck = 1'b1;            // R9: clear
    @(posedge clk); #1;
    irqAck = 1'b0;
    // R1 R8: size 0 means 256 bytes; count 0 means 65536, no irq
    runBlock(32'h0000_0100, 32'h0000_3000, 8'd0, 16'd0, 2'd0, 1'b1, 2'd0, 1'b0);
    // R5: mode 3 holds; unit code 3 acts as longword
    runBlock(32'h0000_7000, 32'h0000_9000, 8'd2, 16'd5, 2'd3, 1'b0, 2'd3, 1'b0);
    // R9: acknowledge held while a new interrupt is raised; set wins
    irqAck = 1'b1;
    runBlock(32'h0000_A000, 32'h0000_B000, 8'd1, 16'd1, 2'd0, 1'b1, 2'd1, 1'b0);
    @(posedge clk); #1;
    irqAck = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(expX.size() == 0, "R1", "leftover accesses", 32'(expX.size()), 0);
    check(expW.size() == 0, "R6", "leftover writebacks", 32'(expW.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule